// File: doc/BRIEF.md
# Temperature-Adaptive DRAM Self-Refresh Sequencer

This block paces the refresh of a DRAM array while it sits in self-refresh, and it keeps an external thermometer powered only when a reading is needed. When the self-refresh enable goes high, the block first refreshes every row back to back at a fixed short spacing. This brings every cell to a known state, whatever the earlier traffic did to it. Once the last row of this burst has been requested, the block powers the thermometer, waits for a result, and from then on spaces row refreshes by an interval taken from the measured temperature. Hotter readings give shorter intervals.

The thermometer is powered again each time the row counter completes a full pass, so the block takes one measurement per pass over the array. While a measurement is pending, refreshes keep going at the interval in force. When the enable drops, refreshing stops, the thermometer is switched off and the block returns to idle. Each new entry begins with a fresh burst.

All timing counts cycles of the single clock. The burst spacing, the base interval, the number of temperature bands and their width, and the row count are parameters.

Top module: `adaptive_sref_ctrl`

## Requirements
- R1: During and directly after a synchronous reset, `ref_req` and `therm_en` are low and the block is idle.
- R2: If `sref_en` is high at clock edge n while the block is idle, the first `ref_req` strobe (one cycle wide, row 0) follows edge n+1. Further burst strobes follow every BURST_GAP cycles with rows ascending by one up to ROWS-1. `therm_en` stays low during the burst.
- R3: `therm_en` rises on the same edge as the burst strobe for row ROWS-1. The first adaptive strobe, for row 0, comes the shortest interval (BASE_INTV >> (NBANDS-1)) cycles after that.
- R4: In the adaptive phase, consecutive strobes are spaced by the interval in force, and rows ascend by one and wrap from ROWS-1 to 0.
- R5: A captured reading `temp_code` maps to band b = min(floor(temp_code / BAND_STEP), NBANDS-1), and the interval becomes BASE_INTV >> b cycles.
- R6: The all-ones code of `temp_code` marks an invalid reading and selects the shortest interval.
- R7: A reading is captured on an edge where `temp_valid` and `therm_en` are both high. The gap that ends at the next strobe keeps the old interval. Every gap after that strobe uses the new one.
- R8: `therm_en` goes low on the edge that captures a reading. A `temp_valid` pulse while `therm_en` is low has no effect on the spacing.
- R9: In the adaptive phase, the strobe for row ROWS-1 raises `therm_en` again for a new measurement.
- R10: When `sref_en` is low at an edge while the block is active, no strobe is issued from that edge on, `therm_en` is low after it, and the block is idle. A later entry starts a new burst from row 0 at the burst spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| sref_en | input | 1 | Self-refresh enable |
| temp_valid | input | 1 | Thermometer result valid |
| temp_code | input | TEMP_W | Thermometer result; all ones means invalid |
| ref_req | output | 1 | One-cycle row refresh request |
| ref_row | output | $clog2(ROWS) | Row addressed by the current request |
| therm_en | output | 1 | Thermometer power enable |

## Verification
A corrupted row counter shows at once as a row address that skips or repeats. It also moves the edge on which `therm_en` rises away from the last-row strobe within one pass. A wrong pacer load or a stale interval register changes the very next gap between strobes, so the bench measures every gap in cycles and compares it with the interval expected from the last captured reading. A wrong phase state shows either as a burst that is too short or too long, which moves the first adaptive strobe, or as a thermometer that is powered during the burst or stays powered after exit. The bench checks both within one clock of the event.

// File: rtl/sref_pkg.sv
package sref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_ADAPT = 2'd2
  } sref_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sref_band_lut.sv
module sref_band_lut #(
  parameter int TEMP_W    = 8,
  parameter int NBANDS    = 4,
  parameter int BAND_STEP = 32,
  parameter int BASE_INTV = 15625,
  parameter int CNT_W     = 14
) (
  input  logic [TEMP_W-1:0] code,
  output logic [CNT_W-1:0]  intv
);
  localparam int BAND_W = (NBANDS > 1) ? $clog2(NBANDS) + 1 : 1;

  logic [NBANDS-1:0] above;
  logic [BAND_W-1:0] band;
  logic              bad_code;

  assign above[0] = 1'b0;

  // one threshold comparator per band boundary
  genvar g;
  generate
    for (g = 1; g < NBANDS; g++) begin : g_thr
      assign above[g] = (int'(code) >= g * BAND_STEP);
    end
  endgenerate

  assign bad_code = &code;

  always_comb begin
    band = '0;
    for (int i = 1; i < NBANDS; i++) begin
      if (above[i]) band = band + 1'b1;
    end
    if (bad_code) band = BAND_W'(NBANDS - 1);
  end

  assign intv = CNT_W'(BASE_INTV) >> band;
endmodule

// File: rtl/sref_pacer.sv
module sref_pacer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sref_row_ctr.sv
module sref_row_ctr #(
  parameter int ROWS = 8192
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    step,
  output logic [$clog2(ROWS)-1:0] row,
  output logic                    last
);
  localparam int ROW_W = $clog2(ROWS);

  assign last = (row == ROW_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= '0;
    end else if (step) begin
      row <= last ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/adaptive_sref_ctrl.sv
module adaptive_sref_ctrl
  import sref_pkg::*;
#(
  parameter int ROWS      = 8192,
  parameter int BURST_GAP = 250,
  parameter int BASE_INTV = 15625,
  parameter int NBANDS    = 4,
  parameter int TEMP_W    = 8,
  parameter int BAND_STEP = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sref_en,
  input  logic                    temp_valid,
  input  logic [TEMP_W-1:0]       temp_code,
  output logic                    ref_req,
  output logic [$clog2(ROWS)-1:0] ref_row,
  output logic                    therm_en
);
  localparam int ROW_W      = $clog2(ROWS);
  localparam int MAX_SPAN   = max_of(BASE_INTV, BURST_GAP);
  localparam int CNT_W      = $clog2(MAX_SPAN + 1);
  localparam int SHORT_INTV = BASE_INTV >> (NBANDS - 1);

  sref_state_e      state;
  logic [CNT_W-1:0] intv_q;
  logic [CNT_W-1:0] lut_intv;
  logic             pace_load;
  logic [CNT_W-1:0] pace_val;
  logic             pace_zero;
  logic             row_clr;
  logic             row_step;
  logic [ROW_W-1:0] row_cur;
  logic             row_last;
  logic             issue;
  logic             capture;

  sref_band_lut #(
    .TEMP_W(TEMP_W), .NBANDS(NBANDS), .BAND_STEP(BAND_STEP),
    .BASE_INTV(BASE_INTV), .CNT_W(CNT_W)
  ) i_lut (
    .code(temp_code),
    .intv(lut_intv)
  );

  sref_pacer #(.CNT_W(CNT_W)) i_pacer (
    .clk(clk), .rst(rst), .load(pace_load),
    .load_val(pace_val), .expired(pace_zero)
  );

  sref_row_ctr #(.ROWS(ROWS)) i_rows (
    .clk(clk), .rst(rst), .clr(row_clr), .step(row_step),
    .row(row_cur), .last(row_last)
  );

  assign issue   = (state != ST_IDLE) && sref_en && pace_zero;
  assign capture = (state == ST_ADAPT) && sref_en && therm_en && temp_valid;

  // pacer and row counter steering
  always_comb begin
    pace_load = 1'b0;
    pace_val  = '0;
    row_clr   = 1'b0;
    row_step  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sref_en) begin
          pace_load = 1'b1;
          row_clr   = 1'b1;
        end
      end
      ST_BURST: begin
        if (issue) begin
          pace_load = 1'b1;
          row_step  = 1'b1;
          pace_val  = row_last ? CNT_W'(SHORT_INTV - 1) : CNT_W'(BURST_GAP - 1);
        end
      end
      default: begin
        if (issue) begin
          pace_load = 1'b1;
          row_step  = 1'b1;
          pace_val  = intv_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ref_req  <= 1'b0;
      ref_row  <= '0;
      therm_en <= 1'b0;
      intv_q   <= CNT_W'(SHORT_INTV);
    end else begin
      ref_req <= 1'b0;
      if (state == ST_IDLE) begin
        therm_en <= 1'b0;
        if (sref_en) begin
          state  <= ST_BURST;
          intv_q <= CNT_W'(SHORT_INTV);
        end
      end else if (!sref_en) begin
        state    <= ST_IDLE;
        therm_en <= 1'b0;
      end else begin
        if (capture) begin
          intv_q   <= lut_intv;
          therm_en <= 1'b0;
        end
        if (issue) begin
          ref_req <= 1'b1;
          ref_row <= row_cur;
          if (row_last) begin
            state    <= ST_ADAPT;
            therm_en <= 1'b1;
          end
        end
      end
    end
  end

  // R10: an idle controller neither requests refresh nor powers the thermometer
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!ref_req && !therm_en));

  // R2: thermometer is never powered during the burst
  assert_burst_therm_off_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURST) |-> !therm_en);

  // R9, R3: thermometer power only comes on together with the last-row strobe
  assert_therm_rise_on_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(therm_en) |-> (ref_req && ref_row == ROW_W'(ROWS - 1)));

  // R7: a captured reading switches the thermometer off on the next cycle
  assert_capture_powers_down_R7: assert property (@(posedge clk) disable iff (rst)
    (capture && !(issue && row_last)) |=> !therm_en);

  generate
    if (BURST_GAP > 1) begin : g_gap_chk
      // R2: burst strobes are never back to back
      assert_burst_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BURST && ref_req) |=> !ref_req);
    end
  endgenerate
endmodule

// File: tb/test_adaptive_sref_ctrl.sv
module test_adaptive_sref_ctrl;
  localparam int ROWS      = 8;
  localparam int BURST_GAP = 3;
  localparam int BASE_INTV = 40;
  localparam int NBANDS    = 4;
  localparam int TEMP_W    = 8;
  localparam int BAND_STEP = 32;
  localparam int SHORT     = BASE_INTV >> (NBANDS - 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sref_en = 1'b0;
  logic              temp_valid = 1'b0;
  logic [TEMP_W-1:0] temp_code = '0;
  logic              ref_req;
  logic [2:0]        ref_row;
  logic              therm_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur = SHORT;

  always #2 clk = ~clk;

  adaptive_sref_ctrl #(
    .ROWS(ROWS), .BURST_GAP(BURST_GAP), .BASE_INTV(BASE_INTV),
    .NBANDS(NBANDS), .TEMP_W(TEMP_W), .BAND_STEP(BAND_STEP)
  ) i_adaptive_sref_ctrl (
    .clk(clk), .rst(rst), .sref_en(sref_en), .temp_valid(temp_valid),
    .temp_code(temp_code), .ref_req(ref_req), .ref_row(ref_row),
    .therm_en(therm_en)
  );

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_intv(input int code);
    int b;
    if (code == (1 << TEMP_W) - 1) return SHORT;
    b = code / BAND_STEP;
    if (b > NBANDS - 1) b = NBANDS - 1;
    return BASE_INTV >> b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_req(input int gap, input int row, input int start_n, input string tag);
    int n = start_n;
    do begin
      @(negedge clk);
      n++;
    end while (!ref_req && n < gap + 20);
    check(n == gap, {tag, " strobe gap"}, n, gap);
    check(int'(ref_row) == row, {tag, " row"}, int'(ref_row), row);
  endtask

  task automatic quiet(input int cycles, input string tag);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ref_req || therm_en) seen++;
    end
    check(seen == 0, {tag, " quiet while idle"}, seen, 0);
  endtask

  // entry into self-refresh and the full burst: R2, R3
  task automatic do_burst(input string tag);
    @(negedge clk);
    sref_en = 1'b1;
    expect_req(2, 0, 0, {tag, " R2 first burst"});
    for (int r = 1; r < ROWS; r++) begin
      check(therm_en == 1'b0, "R2 thermometer off in burst", therm_en, 0);
      expect_req(BURST_GAP, r, 0, "R2 burst");
    end
    check(therm_en == 1'b1, "R3 thermometer on with last burst row", therm_en, 1);
    cur = SHORT;
  endtask

  // one measurement plus one pass over the rows: R4 R5 R6 R7 R8 R9
  task automatic meas_pass(input int code, input int d, input bit poke, input string tag);
    int n = 0;
    for (int i = 0; i < d - 1; i++) begin
      @(negedge clk);
      n++;
    end
    check(therm_en == 1'b1, "R8 thermometer on before result", therm_en, 1);
    temp_valid = 1'b1;
    temp_code  = TEMP_W'(code);
    @(negedge clk);
    n++;
    temp_valid = 1'b0;
    check(therm_en == 1'b0, "R8 thermometer off after capture", therm_en, 0);
    expect_req(cur, 0, n, "R7 old interval kept (R3 after burst)");
    cur = exp_intv(code);
    for (int r = 1; r < ROWS; r++) begin
      if (poke && r == 4) begin
        temp_valid = 1'b1;
        temp_code  = '0;
        @(negedge clk);
        temp_valid = 1'b0;
        expect_req(cur, r, 1, "R8 stray valid ignored");
      end else begin
        expect_req(cur, r, 0, {tag, " R4 adaptive spacing"});
      end
    end
    check(therm_en == 1'b1, "R9 thermometer on at row wrap", therm_en, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ref_req == 1'b0, "R1 reset ref_req", ref_req, 0);
    check(therm_en == 1'b0, "R1 reset therm_en", therm_en, 0);
    rst = 1'b0;
    quiet(6, "R1");

    do_burst("entry");
    meas_pass(40, 1, 1'b1, "R5 band1");
    meas_pass(255, 2, 1'b0, "R6 invalid code");
    meas_pass(31, 1, 1'b0, "R5 band0 edge");
    meas_pass(32, 3, 1'b0, "R5 band1 edge");
    meas_pass(95, 2, 1'b0, "R5 band2");
    meas_pass(96, 1, 1'b0, "R5 band3 edge");
    meas_pass(200, 2, 1'b0, "R5 clamp");
    for (int k = 0; k < 6; k++) begin
      meas_pass(int'($urandom % 256), 1 + int'($urandom % 3), 1'b0, "R5 random");
    end

    // exit while a measurement is pending: R10
    sref_en = 1'b0;
    @(negedge clk);
    check(therm_en == 1'b0, "R10 thermometer off on exit", therm_en, 0);
    quiet(60, "R10");

    // re-entry restarts the burst, then exit in mid-pass
    do_burst("R10 re-entry");
    meas_pass(10, 1, 1'b0, "R5 band0");
    expect_req(cur, 0, 0, "R4 wrap to row 0");
    expect_req(cur, 1, 0, "R4");
    sref_en = 1'b0;
    quiet(100, "R10 mid-pass");

    do_burst("R10 second re-entry");
    meas_pass(70, 2, 1'b0, "R5 band2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule